// File: doc/BRIEF.md
# Capture-Only Boundary Test Port Controller

This block is a serial test access port in the IEEE 1149.1 style. It runs the full sixteen-state controller, which advances on every rising edge of the test clock under control of the mode-select input. A three-bit instruction register chooses which data register sits between the serial input and the serial output. The choices are a one-bit bypass stage, a 32-bit identification word, or a boundary chain of parameterized length.

The boundary chain only takes snapshots of a parallel vector of pin levels. It never drives those pins. Two instructions use the chain. One of them also raises a flag that tells the surrounding design to float its data outputs. The port is otherwise independent of the functional logic, so test activity leaves normal operation undisturbed.

The serial output and its enable are updated on the falling edge of the test clock. An optional synchronous reset, active high, is provided. Holding mode-select high for five clocks also returns the controller to its reset state.

Top module: `jtag_tap_ctl`

## Requirements
- R1: The controller follows the 1149.1 state graph, sampling `tms` on the rising edge of `tck`. Five consecutive rising edges with `tms` high bring it to Test-Logic-Reset from any state.
- R2: With `trst` high at a rising edge, the controller enters Test-Logic-Reset. The active instruction becomes 3'b001, and `tdo_oe` is low after the next falling edge.
- R3: While the controller is in Test-Logic-Reset, the active instruction is forced to 3'b001 (identification).
- R4: The instruction register is 3 bits wide. It loads the pattern 3'b001 in Capture-IR, then shifts in Shift-IR with bit 0 leaving first. The shifted value becomes the active instruction only in Update-IR.
- R5: Under instruction 3'b001, Capture-DR loads the 32-bit `ID_VALUE`, whose bit 0 is 1. Shift-DR then emits it with bit 0 first, followed by the bits shifted in on `tdi`.
- R6: Under instructions 3'b000 and 3'b010, Capture-DR loads `pins_in` into a `BSR_LEN`-bit chain. Shift-DR emits `pins_in[0]` first; after `BSR_LEN` bits, the bits shifted in on `tdi` follow.
- R7: Under any of the codes 3'b011 through 3'b111, the data path is a single bypass stage. It captures 0 and delays `tdi` by one clock in Shift-DR.
- R8: `mem_hiz` is high exactly while the active instruction is 3'b010.
- R9: `tdo` and `tdo_oe` change only on falling edges of `tck`. `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR.
- R10: Changes on `pins_in` after Capture-DR have no effect on the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high port reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| pins_in | input | BSR_LEN | Pin levels to snapshot |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | Serial output enable |
| mem_hiz | output | 1 | Request to float functional data outputs |

## Verification
A single data-register scan is run under every one of the eight instruction codes, each with a different pin pattern. The length of the path and the captured prefix then separate the identification word, the boundary chain and the bypass stage, and show that the two chain-using codes behave alike apart from `mem_hiz`. Further scans cover several situations:
- reset by `trst` and by holding mode-select high from inside Shift-DR, which separates the two reset routes;
- pins changed in the middle of a shift;
- a check of `tdo` between the rising and falling edges, which shows whether the output moves on the wrong edge.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    localparam int IR_W = 3;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_e;

    typedef struct packed {
        logic tlr;
        logic cap;
        logic sh;
        logic upd;
    } ir_ctl_t;

    typedef struct packed {
        logic cap;
        logic sh;
    } dr_ctl_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        case (s)
            ST_TLR:    return tms ? ST_TLR    : ST_RTI;
            ST_RTI:    return tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: return tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
            default:   return tms ? ST_SEL_DR : ST_RTI;
        endcase
    endfunction

    function automatic dr_path_e decode_path(logic [IR_W-1:0] op);
        if (op == OP_IDCODE)                        return PATH_ID;
        if (op == OP_EXTEST || op == OP_SAMPLEZ)    return PATH_BSR;
        return PATH_BYP;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state,
    output ir_ctl_t    ir_ctl,
    output dr_ctl_t    dr_ctl
);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_TLR;
        else     state <= tap_next(state, tms);
    end

    always_comb begin
        ir_ctl.tlr = (state == ST_TLR);
        ir_ctl.cap = (state == ST_CAP_IR);
        ir_ctl.sh  = (state == ST_SH_IR);
        ir_ctl.upd = (state == ST_UPD_IR);
        dr_ctl.cap = (state == ST_CAP_DR);
        dr_ctl.sh  = (state == ST_SH_DR);
    end

    // checker: run length of consecutive high mode-select samples
    logic [2:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst || !tms)      hi_run <= '0;
        else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
    end

    p_five_high_reset_r1: assert property (@(posedge clk) disable iff (rst)
        (hi_run == 3'd5) |-> (state == ST_TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  ir_ctl_t         ctl,
    input  logic            tdi,
    output logic [IR_W-1:0] op,
    output logic            ir_so
);

    logic [IR_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst || ctl.tlr) begin
            op <= OP_IDCODE;
            sr <= IR_CAPTURE;
        end else begin
            if (ctl.cap)     sr <= IR_CAPTURE;
            else if (ctl.sh) sr <= {tdi, sr[IR_W-1:1]};
            if (ctl.upd)     op <= sr;
        end
    end

    assign ir_so = sr[0];

    p_tlr_forces_id_r3: assert property (@(posedge clk) disable iff (rst)
        ctl.tlr |=> (op == OP_IDCODE));

    p_op_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.upd && !ctl.tlr) |=> $stable(op));

    p_ir_capture_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.cap |=> (sr == IR_CAPTURE));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_LEN  = 8,
    parameter logic [31:0] ID_VALUE = 32'h0A5C_3069
) (
    input  logic               clk,
    input  logic               rst,
    input  dr_ctl_t            ctl,
    input  dr_path_e           path,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pins_in,
    output logic               dr_so
);

    localparam int ID_W = 32;

    logic               byp_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] bsr_q;
    logic               sel_byp, sel_id, sel_bsr;

    assign sel_byp = (path == PATH_BYP);
    assign sel_id  = (path == PATH_ID);
    assign sel_bsr = (path == PATH_BSR);

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_q <= 1'b0;
            id_q  <= ID_VALUE;
        end else begin
            if (sel_byp && ctl.cap)     byp_q <= 1'b0;
            else if (sel_byp && ctl.sh) byp_q <= tdi;
            if (sel_id && ctl.cap)      id_q  <= ID_VALUE;
            else if (sel_id && ctl.sh)  id_q  <= {tdi, id_q[ID_W-1:1]};
        end
    end

    generate
        if (BSR_LEN > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst)                      bsr_q <= '0;
                else if (sel_bsr && ctl.cap)  bsr_q <= pins_in;
                else if (sel_bsr && ctl.sh)   bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst)                      bsr_q <= '0;
                else if (sel_bsr && ctl.cap)  bsr_q <= pins_in;
                else if (sel_bsr && ctl.sh)   bsr_q <= tdi;
            end
        end
    endgenerate

    always_comb begin
        case (path)
            PATH_ID:  dr_so = id_q[0];
            PATH_BSR: dr_so = bsr_q[0];
            default:  dr_so = byp_q;
        endcase
    end

    p_byp_capture_r7: assert property (@(posedge clk) disable iff (rst)
        (sel_byp && ctl.cap) |=> (byp_q == 1'b0));

    p_id_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_id && ctl.cap) |=> (id_q == ID_VALUE && id_q[0]));

    p_bsr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(sel_bsr && (ctl.cap || ctl.sh)) |=> $stable(bsr_q));

endmodule

// File: rtl/jtag_tap_ctl.sv
module jtag_tap_ctl
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_LEN  = 8,
    parameter logic [31:0] ID_VALUE = 32'h0A5C_3069
) (
    input  logic               tck,
    input  logic               trst,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pins_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic               mem_hiz
);

    tap_state_e      state;
    ir_ctl_t         ir_ctl;
    dr_ctl_t         dr_ctl;
    logic [IR_W-1:0] op;
    logic            ir_so, dr_so;
    dr_path_e        path;

    tap_fsm u_fsm (
        .clk    (tck),
        .rst    (trst),
        .tms    (tms),
        .state  (state),
        .ir_ctl (ir_ctl),
        .dr_ctl (dr_ctl)
    );

    tap_ir u_ir (
        .clk   (tck),
        .rst   (trst),
        .ctl   (ir_ctl),
        .tdi   (tdi),
        .op    (op),
        .ir_so (ir_so)
    );

    assign path = decode_path(op);

    tap_dr #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) u_dr (
        .clk     (tck),
        .rst     (trst),
        .ctl     (dr_ctl),
        .path    (path),
        .tdi     (tdi),
        .pins_in (pins_in),
        .dr_so   (dr_so)
    );

    always_ff @(negedge tck) begin
        if (trst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= ir_ctl.sh ? ir_so : dr_so;
            tdo_oe <= ir_ctl.sh || dr_ctl.sh;
        end
    end

    assign mem_hiz = (op == OP_SAMPLEZ);

    p_oe_in_shift_r9: assert property (@(posedge tck) disable iff (trst)
        tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR));

endmodule

// File: tb/tb_jtag_tap_ctl.sv
module tb_jtag_tap_ctl;

    localparam int          NB    = 8;
    localparam logic [31:0] IDW   = 32'h0A5C_3069;
    localparam int          SHN   = 40;
    localparam int          NVEC  = 8;

    logic tck = 1'b0;
    logic trst = 1'b1, tms = 1'b1, tdi = 1'b0;
    logic [NB-1:0] pins_in = '0;
    logic tdo, tdo_oe, mem_hiz;

    int checks = 0;
    int failures = 0;

    always #10 tck = ~tck;

    jtag_tap_ctl #(.BSR_LEN(NB), .ID_VALUE(IDW)) dut (
        .tck(tck), .trst(trst), .tms(tms), .tdi(tdi),
        .pins_in(pins_in), .tdo(tdo), .tdo_oe(tdo_oe), .mem_hiz(mem_hiz)
    );

    // {instruction code, pin pattern}
    localparam logic [10:0] VEC [NVEC] = '{
        {3'b001, 8'h00}, {3'b000, 8'hA5}, {3'b010, 8'h3C}, {3'b111, 8'hFF},
        {3'b011, 8'h81}, {3'b100, 8'h5A}, {3'b101, 8'h96}, {3'b110, 8'h01}
    };

    localparam logic [63:0] STIM = 64'hC6F1_9B27_4D3A_E581;

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic step(logic m, logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    // expected serial stream for a 40-bit DR scan
    function automatic logic [63:0] exp_stream(logic [2:0] code, logic [NB-1:0] pins,
                                               logic [63:0] sin);
        logic [63:0] r = '0;
        for (int i = 0; i < SHN; i++) begin
            if (code == 3'b001)                       r[i] = (i < 32) ? IDW[i] : sin[i-32];
            else if (code == 3'b000 || code == 3'b010) r[i] = (i < NB) ? pins[i] : sin[i-NB];
            else                                       r[i] = (i == 0) ? 1'b0 : sin[i-1];
        end
        return r;
    endfunction

    task automatic load_ir(logic [2:0] code, output logic [2:0] cap);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) begin
            cap[i] = tdo;
            step(i == 2, code[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(logic [NB-1:0] p_cap, logic [NB-1:0] p_late,
                           output logic [63:0] sout, output logic oe_in);
        sout = '0;
        pins_in = p_cap;
        step(1, 0); step(0, 0); step(0, 0);
        pins_in = p_late;
        oe_in = tdo_oe;
        for (int i = 0; i < SHN; i++) begin
            sout[i] = tdo;
            step(i == SHN - 1, STIM[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [2:0]  cap;
        logic [63:0] sout;
        logic        oe_in;

        @(negedge tck); #1;
        step(1, 0); step(1, 0); step(1, 0);
        trst = 1'b0;
        // R2 reset state
        chk("R2 oe after reset", tdo_oe, 0);
        chk("R8 hiz after reset", mem_hiz, 0);
        step(0, 0);
        scan_dr(8'h00, 8'h00, sout, oe_in);
        chk("R3 R5 id after reset", sout, exp_stream(3'b001, 8'h00, STIM));

        // table walk over every instruction code
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0]    code;
            logic [NB-1:0] pp;
            code = VEC[v][10:8];
            pp   = VEC[v][7:0];
            load_ir(code, cap);
            chk("R4 ir capture", cap, 3'b001);
            chk("R8 hiz per code", mem_hiz, code == 3'b010);
            scan_dr(pp, pp, sout, oe_in);
            chk("R9 oe in shift", oe_in, 1);
            chk("R9 oe after scan", tdo_oe, 0);
            chk(code == 3'b001 ? "R5 id path" :
                (code == 3'b000 || code == 3'b010) ? "R6 chain path" : "R7 bypass path",
                sout, exp_stream(code, pp, STIM));
        end

        // R10: pins change after capture
        load_ir(3'b000, cap);
        scan_dr(8'hC3, 8'h18, sout, oe_in);
        chk("R10 pins ignored after capture", sout, exp_stream(3'b000, 8'hC3, STIM));

        // R1: five high mode-select samples from Shift-DR, with SAMPLE Z active
        load_ir(3'b010, cap);
        chk("R8 hiz set", mem_hiz, 1);
        step(1, 0); step(0, 0); step(0, 0);
        for (int k = 0; k < 5; k++) step(1, 0);
        chk("R1 oe off in reset", tdo_oe, 0);
        step(0, 0);
        chk("R1 R8 hiz cleared by tms reset", mem_hiz, 0);
        scan_dr(8'h00, 8'h00, sout, oe_in);
        chk("R1 R3 id after tms reset", sout, exp_stream(3'b001, 8'h00, STIM));

        // R9: tdo moves only on the falling edge
        load_ir(3'b111, cap);
        step(1, 0); step(0, 0); step(0, 0);
        chk("R7 bypass captured zero", tdo, 0);
        tms = 1'b0; tdi = 1'b1;
        @(posedge tck); #1;
        chk("R9 tdo held after rising edge", tdo, 0);
        @(negedge tck); #1;
        chk("R9 tdo updated on falling edge", tdo, 1);

        // R2: trst from inside Shift-DR
        trst = 1'b1;
        step(0, 0);
        trst = 1'b0;
        chk("R2 oe after trst", tdo_oe, 0);
        step(0, 0);
        scan_dr(8'h00, 8'h00, sout, oe_in);
        chk("R2 id after trst", sout, exp_stream(3'b001, 8'h00, STIM));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule